// File: doc/BRIEF.md
# Dual-Channel DAC Serial Load Controller

This block is the digital front end of a two-channel voltage-output converter. A host sends 24-bit frames over three wires: an active-low frame select, a serial clock and a data line. The block collects the frame, decodes a command and a channel address, and writes a code into a per-channel staging register, into the channel's output register, or into both. The output registers drive the converter cores. Data is taken most significant bit first, on falling edges of the serial clock.

Output registers are loaded in one of two ways. In the first, an active-low load strobe is held low and each completed frame reaches the output at once. In the second, the strobe is held high while frames fill the staging registers, and a falling edge on the strobe then copies every staging register into its output register in the same cycle.

A falling edge on the clear input forces every register to the reset code and abandons any frame in progress. A build parameter makes the reset code either zero scale or mid-scale. All pins are synchronised to the system clock, and edges are found by comparing each pin with its value one cycle earlier. No logic is clocked by the serial clock.

Top module: `dual_dac_loader`

## Requirements
- R1: After reset, both output codes and both staging registers hold the reset code: zero when RESET_MID is 0, and only the MSB set when RESET_MID is 1. clear_active is 0.
- R2: A frame is 24 bits, sent MSB first and sampled on falling serial-clock edges while frame_n is low. Bits 23:22 are the command, bits 21:19 the address, bits 18:16 are spare, and bits 15:0 are the data field. A frame takes effect on its 24th falling edge.
- R3: Address 000 selects channel A, 001 selects channel B, and 111 selects both. Any other address selects no channel.
- R4: Command 00 writes the data into the addressed staging registers. If load_n is low when the frame completes, the same data also goes into the addressed output registers.
- R5: With load_n high, command 00 leaves the output registers unchanged.
- R6: A falling edge on load_n copies both staging registers into their output registers at the same time.
- R7: Command 01 writes the data into the addressed staging and output registers, whatever the level of load_n.
- R8: Command 10 copies all staging registers into the output registers. Command 11 changes no register.
- R9: A frame whose frame_n rises before its 24th falling edge is discarded. Clock edges after the 24th, and clock edges while frame_n is high, are ignored. The bit count restarts each time frame_n goes high.
- R10: A falling edge on clear_n loads the reset code into every staging and output register, sets clear_active, and aborts any frame in progress until frame_n next goes high.
- R11: clear_active stays set through aborted frames and drops at the 24th falling edge of the next complete frame.
- R12: The code is the top DATA_W bits of the 16-bit data field. Lower bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low frame select |
| ser_clk | input | 1 | Serial clock; data is sampled on its falling edge |
| ser_data | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Active-low load strobe; a level of 0 means immediate update, a falling edge loads both channels together |
| clear_n | input | 1 | Clear; acts on its falling edge |
| code_a | output | DATA_W | Output register of channel A |
| code_b | output | DATA_W | Output register of channel B |
| clear_active | output | 1 | High from a clear until the next complete frame |

## Verification
The hardest case to reach is a clear that lands in the middle of a frame while the host keeps clocking. The rest of that frame must be dropped, and the staging registers must also hold the reset code, but they cannot be seen at the pins. The bench starts a frame, pulses clear_n after ten bits, then clocks the remaining fourteen bits. It checks that the outputs show the reset code and that clear_active stays set. It then sends a command-10 frame: copying the staging registers to the outputs exposes their reset contents and ends clear mode.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  typedef enum logic [1:0] {
    CMD_WR_STAGE = 2'b00,
    CMD_WR_BOTH  = 2'b01,
    CMD_LOAD_ALL = 2'b10,
    CMD_NOP      = 2'b11
  } cmd_e;

  typedef struct packed {
    cmd_e        cmd;
    logic [2:0]  addr;
    logic [2:0]  spare;
    logic [15:0] data;
  } frame_t;

  localparam int FRAME_BITS = $bits(frame_t);
  localparam int FIELD_W    = 16;
  localparam logic [2:0] ADDR_ALL = 3'b111;
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int         W      = 5,
  parameter int         STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins,
  output logic [W-1:0] level,
  output logic [W-1:0] fall
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= INIT;
    else     stage_q[0] <= pins;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= INIT;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= INIT;
    else     prev_q <= stage_q[STAGES-1];
  end

  assign level = stage_q[STAGES-1];
  assign fall  = prev_q & ~level;
endmodule

// File: rtl/dacif_frame_rx.sv
module dacif_frame_rx
  import dacif_pkg::*;
#(
  parameter int NBITS = FRAME_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_lvl,
  input  logic             sclk_fall,
  input  logic             sdata_lvl,
  input  logic             clr_fall,
  output logic             commit,
  output logic [NBITS-1:0] word
);
  localparam int CW = $clog2(NBITS);
  localparam logic [CW-1:0] LAST = CW'(NBITS - 1);

  logic [NBITS-2:0] shreg_q;
  logic [CW-1:0]    cnt_q;
  logic             blocked_q;
  logic             take;

  assign take   = sclk_fall && !frame_lvl && !blocked_q && !clr_fall;
  assign commit = take && (cnt_q == LAST);
  assign word   = {shreg_q, sdata_lvl};

  always_ff @(posedge clk) begin
    if (rst || frame_lvl) begin
      cnt_q     <= '0;
      blocked_q <= 1'b0;
      shreg_q   <= '0;
    end else if (clr_fall) begin
      cnt_q     <= '0;
      blocked_q <= 1'b1;
    end else if (take) begin
      shreg_q <= word[NBITS-2:0];
      cnt_q   <= commit ? '0 : cnt_q + 1'b1;
      if (commit) blocked_q <= 1'b1;
    end
  end

  // R2
  cnt_limit_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R9
  commit_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    commit |-> !frame_lvl);

  // R9
  idle_count_chk: assert property (@(posedge clk) disable iff (rst)
    frame_lvl |=> (cnt_q == '0));

  // R10
  clear_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_fall && !frame_lvl) |=> !commit);
endmodule

// File: rtl/dacif_regbank.sv
module dacif_regbank
  import dacif_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int DATA_W    = 16,
  parameter bit RESET_MID = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  commit,
  input  frame_t                word,
  input  logic                  load_lvl,
  input  logic                  load_fall,
  input  logic                  clr_fall,
  output logic [NCH*DATA_W-1:0] codes,
  output logic                  clear_active
);
  localparam logic [DATA_W-1:0] RST_CODE =
    RESET_MID ? {1'b1, {(DATA_W-1){1'b0}}} : '0;

  logic [DATA_W-1:0] stage_q [NCH];
  logic [DATA_W-1:0] dac_q   [NCH];
  logic [DATA_W-1:0] new_code;
  logic              unused_bits;

  assign new_code    = word.data[FIELD_W-1 -: DATA_W];
  assign unused_bits = ^{word.spare, word.data};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic hit, wr_stage, wr_dac, copy;
    assign hit      = commit && ((word.addr == ADDR_ALL) || (word.addr == 3'(ch)));
    assign wr_stage = hit && ((word.cmd == CMD_WR_STAGE) || (word.cmd == CMD_WR_BOTH));
    assign wr_dac   = hit && ((word.cmd == CMD_WR_BOTH) ||
                              ((word.cmd == CMD_WR_STAGE) && !load_lvl));
    assign copy     = (commit && (word.cmd == CMD_LOAD_ALL)) || load_fall;

    always_ff @(posedge clk) begin
      if (rst || clr_fall) begin
        stage_q[ch] <= RST_CODE;
        dac_q[ch]   <= RST_CODE;
      end else begin
        if (wr_stage) stage_q[ch] <= new_code;
        if (wr_dac)    dac_q[ch] <= new_code;
        else if (copy) dac_q[ch] <= stage_q[ch];
      end
    end

    assign codes[ch*DATA_W +: DATA_W] = dac_q[ch];

    // R10
    clear_code_chk: assert property (@(posedge clk) disable iff (rst)
      clr_fall |=> (dac_q[ch] == RST_CODE) && (stage_q[ch] == RST_CODE));

    // R5
    hold_dac_chk: assert property (@(posedge clk) disable iff (rst)
      !(commit || load_fall || clr_fall) |=> $stable(dac_q[ch]));
  end

  always_ff @(posedge clk) begin
    if (rst)           clear_active <= 1'b0;
    else if (clr_fall) clear_active <= 1'b1;
    else if (commit)   clear_active <= 1'b0;
  end

  // R11
  clear_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(clear_active) |-> $past(commit));

  // R10
  clear_enter_chk: assert property (@(posedge clk) disable iff (rst)
    clr_fall |=> clear_active);
endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
  import dacif_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter bit RESET_MID   = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              load_n,
  input  logic              clear_n,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b,
  output logic              clear_active
);
  localparam int NCH = 2;
  localparam int NP  = 5;
  // pin order: clear_n, load_n, frame_n, ser_data, ser_clk
  localparam logic [NP-1:0] PIN_IDLE = 5'b11100;

  logic [NP-1:0]         lvl, fall;
  logic                  commit;
  logic [FRAME_BITS-1:0] word;
  logic [NCH*DATA_W-1:0] codes;
  logic                  unused_pins;

  dacif_sync #(.W(NP), .STAGES(SYNC_STAGES), .INIT(PIN_IDLE)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pins  ({clear_n, load_n, frame_n, ser_data, ser_clk}),
    .level (lvl),
    .fall  (fall)
  );

  assign unused_pins = ^{lvl[4], lvl[0], fall[2], fall[1]};

  dacif_frame_rx #(.NBITS(FRAME_BITS)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .frame_lvl (lvl[2]),
    .sclk_fall (fall[0]),
    .sdata_lvl (lvl[1]),
    .clr_fall  (fall[4]),
    .commit    (commit),
    .word      (word)
  );

  dacif_regbank #(.NCH(NCH), .DATA_W(DATA_W), .RESET_MID(RESET_MID)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .commit       (commit),
    .word         (frame_t'(word)),
    .load_lvl     (lvl[3]),
    .load_fall    (fall[3]),
    .clr_fall     (fall[4]),
    .codes        (codes),
    .clear_active (clear_active)
  );

  assign code_a = codes[DATA_W-1:0];
  assign code_b = codes[2*DATA_W-1:DATA_W];
endmodule

// File: tb/dual_dac_loader_bench.sv
module dual_dac_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam logic [DW-1:0] RSTC = 12'h800;
  localparam int NV = 10;
  // {load_n, cmd[1:0], addr[2:0], data[15:0]}
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 2'b00, 3'b000, 16'hABCD},
    {1'b0, 2'b00, 3'b001, 16'h1234},
    {1'b0, 2'b00, 3'b111, 16'hFFFF},
    {1'b1, 2'b00, 3'b000, 16'h5555},
    {1'b1, 2'b01, 3'b001, 16'h0F0F},
    {1'b1, 2'b10, 3'b000, 16'h0000},
    {1'b0, 2'b00, 3'b010, 16'h7777},
    {1'b0, 2'b11, 3'b111, 16'h9999},
    {1'b0, 2'b00, 3'b000, 16'h000F},
    {1'b1, 2'b00, 3'b111, 16'h8421}
  };

  logic clk = 0, rst = 1;
  logic frame_n = 1, ser_clk = 0, ser_data = 0, load_n = 1, clear_n = 1;
  logic [DW-1:0] code_a, code_b;
  logic clear_active;
  int checks = 0, errors = 0, cycles = 0;
  logic [DW-1:0] m_in_a, m_in_b, m_dac_a, m_dac_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dac_loader #(.DATA_W(DW), .RESET_MID(1'b1)) u_dual_dac_loader (
    .clk(clk), .rst(rst), .frame_n(frame_n), .ser_clk(ser_clk),
    .ser_data(ser_data), .load_n(load_n), .clear_n(clear_n),
    .code_a(code_a), .code_b(code_b), .clear_active(clear_active)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: act=%0d exp<=150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, code_a, m_dac_a);
    check(req, code_b, m_dac_b);
    check(req, DW'(clear_active), '0);
  endtask

  task automatic frame_begin();
    frame_n = 0; wait_clk(4);
  endtask

  task automatic frame_end();
    wait_clk(6); frame_n = 1; wait_clk(6);
  endtask

  task automatic shift_bits(input logic [23:0] w, input int from, input int count);
    for (int i = from; i < from + count; i++) begin
      ser_data = w[23-i]; wait_clk(2);
      ser_clk = 1; wait_clk(4);
      ser_clk = 0; wait_clk(4);
    end
  endtask

  task automatic send(input logic [23:0] w);
    frame_begin(); shift_bits(w, 0, 24); frame_end();
  endtask

  task automatic set_load(input logic v);
    if (load_n && !v) begin m_dac_a = m_in_a; m_dac_b = m_in_b; end
    load_n = v; wait_clk(6);
  endtask

  task automatic model(input logic [1:0] cmd, input logic [2:0] addr, input logic [15:0] d);
    logic ha, hb;
    logic [DW-1:0] c;
    ha = (addr == 3'b000) || (addr == 3'b111);
    hb = (addr == 3'b001) || (addr == 3'b111);
    c = d[15:4];
    case (cmd)
      2'b00: begin
        if (ha) begin m_in_a = c; if (!load_n) m_dac_a = c; end
        if (hb) begin m_in_b = c; if (!load_n) m_dac_b = c; end
      end
      2'b01: begin
        if (ha) begin m_in_a = c; m_dac_a = c; end
        if (hb) begin m_in_b = c; m_dac_b = c; end
      end
      2'b10: begin m_dac_a = m_in_a; m_dac_b = m_in_b; end
      default: ;
    endcase
  endtask

  initial begin
    m_in_a = RSTC; m_in_b = RSTC; m_dac_a = RSTC; m_dac_b = RSTC;
    wait_clk(5); rst = 0; wait_clk(5);
    // R1 reset state
    check("R1", code_a, RSTC);
    check("R1", code_b, RSTC);
    check("R1", DW'(clear_active), '0);

    // R2 R3 R4 R5 R7 R8 R12 vector table
    for (int v = 0; v < NV; v++) begin
      logic [21:0] e;
      e = VEC[v];
      set_load(e[21]);
      send({e[20:19], e[18:16], 3'b000, e[15:0]});
      model(e[20:19], e[18:16], e[15:0]);
      check_all("R2/R3/R4/R5/R7/R8/R12 table");
    end

    // R6 falling load strobe copies both staged codes
    check("R5", code_a, 12'h000);
    set_load(1'b0);
    check("R6", code_a, 12'h842);
    check("R6", code_b, 12'h842);

    // R9 early release discards the frame
    frame_begin(); shift_bits({2'b01, 3'b111, 3'b000, 16'h3330}, 0, 20); frame_end();
    check("R9 short20", code_a, 12'h842);
    frame_begin(); shift_bits({2'b01, 3'b111, 3'b000, 16'h3330}, 0, 23); frame_end();
    check("R9 short23", code_b, 12'h842);

    // R9 clock edges with frame high are ignored, counter restarts
    for (int k = 0; k < 5; k++) begin
      ser_clk = 1; wait_clk(4); ser_clk = 0; wait_clk(4);
    end
    send({2'b01, 3'b000, 3'b000, 16'h6540});
    check("R9 idle edges", code_a, 12'h654);

    // R9 edges past the 24th are ignored
    frame_begin();
    shift_bits({2'b01, 3'b001, 3'b000, 16'h2220}, 0, 24);
    shift_bits(24'hFFFFFF, 0, 6);
    frame_end();
    check("R9 extra edges", code_b, 12'h222);

    // R10 clear in the middle of a frame
    frame_begin();
    shift_bits({2'b01, 3'b111, 3'b000, 16'h1110}, 0, 10);
    clear_n = 0; wait_clk(6); clear_n = 1; wait_clk(6);
    shift_bits({2'b01, 3'b111, 3'b000, 16'h1110}, 10, 14);
    frame_end();
    check("R10 code_a", code_a, RSTC);
    check("R10 code_b", code_b, RSTC);
    check("R10 flag", DW'(clear_active), DW'(1));

    // R11 aborted frame keeps clear mode
    frame_begin(); shift_bits({2'b00, 3'b000, 3'b000, 16'h4440}, 0, 12); frame_end();
    check("R11 held", DW'(clear_active), DW'(1));

    // R10 R11 copy-all exposes staged reset codes and ends clear mode
    send({2'b10, 3'b000, 3'b000, 16'h0000});
    check("R10 staged a", code_a, RSTC);
    check("R10 staged b", code_b, RSTC);
    check("R11 exit", DW'(clear_active), '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule